// File: doc/BRIEF.md
# FIFO Level-Crossing Interrupt Generator

This block watches the fill counts of a receive FIFO and a transmit FIFO in a serial port. For each direction it raises an interrupt request when the fill level passes through a trigger point that software selects. A receive request marks a FIFO that has filled up to the point. A transmit request marks a FIFO that has drained down to it. Nothing fires while a level simply stays beyond the point, so a single service routine is requested once for each crossing and not on every cycle.

The FIFOs report their fill count together with their push and pop strobes. In a strobe cycle the count input already shows the level after that access. The block keeps the level seen at the previous access of each FIFO and compares the old and new levels with the selected trigger point. A small word-addressed register port holds the two 3-bit trigger selects and a write-one-to-clear register for the two pending requests. Each request stays high until software clears it.

Top module: `fifo_lvl_irq`

## Requirements
- R1: Word address 0 holds the trigger selects, with the receive select in bits 5:3 and the transmit select in bits 2:0. Both fields are writable and read back, and bits 31:6 read as zero. A read of any other address returns zero.
- R2: After reset both selects hold 010, address 0 reads 0x12, and both interrupt outputs are low.
- R3: For a 16-entry FIFO, receive select codes 000, 001, 010, 011, 100 and 101 give thresholds of 2, 4, 8, 12, 14 and 16 entries. The receive request sets in a strobe cycle where the previous level is below the threshold and the count is at or above it. The output goes high in the cycle after that edge.
- R4: Transmit select codes 000 to 101 give thresholds of 2, 4, 8, 12, 14 and 0 entries. The transmit request sets in a strobe cycle where the previous level is above the threshold and the count is at or below it.
- R5: A request is raised by a crossing only. Further accesses that keep the level at or beyond the threshold raise no new request after a clear. A single step that jumps across the threshold does count as a crossing.
- R6: Select codes 110 and 111 disable their direction, so that request never sets.
- R7: A pending request stays high until a write to word address 1 with bit 0 set (receive) or bit 1 set (transmit). If a clear and a new crossing fall on the same edge, the request stays set.
- R8: Writing a new select value does not raise a request by itself, even when the current level is already beyond the new threshold.
- R9: A direction samples its count only in cycles where its push or pop strobe is high. A count change with no strobe is ignored, and the stored previous level changes only on a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | 5 | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_count | input | 5 | Transmit FIFO fill level |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_irq | output | 1 | Receive level interrupt |
| tx_irq | output | 1 | Transmit level interrupt |

## Verification
Every select code from 000 to 111 is tried on both directions with a slow ramp from empty to full, a drain back to empty and a second ramp. This tells rising crossings apart from falling ones, shows that each code has its own threshold, and shows that the invalid codes stay silent. Single jumps across a threshold and steps that stay beyond it are used to separate detection of a crossing from detection of a level. Count changes with no strobe, select writes made while the level is already past the new threshold, and clears that land on the same edge as a crossing test the gating on strobes and the priority of a set over a clear.

// File: rtl/fli_pkg.sv
package fli_pkg;

    localparam int SEL_W   = 3;
    localparam int REG_DW  = 32;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_SEL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CLR = 2'd1;

    localparam int CLR_RX_BIT = 0;
    localparam int CLR_TX_BIT = 1;

    localparam logic [SEL_W-1:0] SEL_RESET = 3'b010;

    // Packed so the receive field lands in bits 5:3 and transmit in 2:0
    typedef struct packed {
        logic [SEL_W-1:0] rx_sel;
        logic [SEL_W-1:0] tx_sel;
    } sel_regs_t;

    localparam int SEL_REG_W = $bits(sel_regs_t);

endpackage

// File: rtl/fli_regs.sv
module fli_regs
    import fli_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_DW-1:0]     reg_wdata,
    output logic [REG_DW-1:0]     reg_rdata,
    output logic [SEL_W-1:0]      rx_sel,
    output logic [SEL_W-1:0]      tx_sel,
    output logic                  rx_clr,
    output logic                  tx_clr
);

    typedef struct packed {
        sel_regs_t sel;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        wr_sel, wr_clr;
    logic        wdata_unused;

    assign wdata_unused = ^reg_wdata[REG_DW-1:SEL_REG_W];

    always_comb begin
        wr_sel = reg_wr && (reg_addr == ADDR_SEL);
        wr_clr = reg_wr && (reg_addr == ADDR_CLR);
        st_d   = st_q;
        if (wr_sel) begin
            st_d.sel = sel_regs_t'(reg_wdata[SEL_REG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel.rx_sel <= SEL_RESET;
            st_q.sel.tx_sel <= SEL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_SEL) begin
            reg_rdata[SEL_REG_W-1:0] = st_q.sel;
        end
    end

    assign rx_sel = st_q.sel.rx_sel;
    assign tx_sel = st_q.sel.tx_sel;
    assign rx_clr = wr_clr && reg_wdata[CLR_RX_BIT];
    assign tx_clr = wr_clr && reg_wdata[CLR_TX_BIT];

    // R1
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SEL) |=>
            ({rx_sel, tx_sel} == $past(reg_wdata[SEL_REG_W-1:0])));

    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_SEL) |=> $stable({rx_sel, tx_sel}));

endmodule

// File: rtl/fli_thresh.sv
module fli_thresh
    import fli_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter bit RISING = 1'b1
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [CNT_W-1:0]  thr,
    output logic              thr_ok
);

    localparam int LVL_EIGHTH   = DEPTH / 8;
    localparam int LVL_QUARTER  = DEPTH / 4;
    localparam int LVL_HALF     = DEPTH / 2;
    localparam int LVL_3QUARTER = (DEPTH * 3) / 4;
    localparam int LVL_7EIGHTH  = (DEPTH * 7) / 8;
    localparam int LVL_END      = RISING ? DEPTH : 0;

    always_comb begin
        thr    = '0;
        thr_ok = 1'b1;
        unique case (sel)
            3'd0:    thr = CNT_W'(LVL_EIGHTH);
            3'd1:    thr = CNT_W'(LVL_QUARTER);
            3'd2:    thr = CNT_W'(LVL_HALF);
            3'd3:    thr = CNT_W'(LVL_3QUARTER);
            3'd4:    thr = CNT_W'(LVL_7EIGHTH);
            3'd5:    thr = CNT_W'(LVL_END);
            default: thr_ok = 1'b0;
        endcase
    end

    initial begin
        thr_depth_chk: assert (DEPTH % 8 == 0 && DEPTH >= 8);
    end

endmodule

// File: rtl/fli_cross.sv
module fli_cross #(
    parameter int CNT_W  = 5,
    parameter bit RISING = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic              strobe,
    input  logic [CNT_W-1:0]  thr,
    input  logic              thr_ok,
    input  logic              clr,
    output logic              irq
);

    typedef struct packed {
        logic [CNT_W-1:0] last;
        logic             pend;
    } cross_state_t;

    cross_state_t st_d, st_q;
    logic         hit;
    logic         set;
    logic [CNT_W-1:0] last_q;

    assign last_q = st_q.last;

    generate
        if (RISING) begin : g_rise
            assign hit = (last_q < thr) && (count >= thr);
        end else begin : g_fall
            assign hit = (last_q > thr) && (count <= thr);
        end
    endgenerate

    always_comb begin
        set  = strobe && thr_ok && hit;
        st_d = st_q;
        if (strobe) begin
            st_d.last = count;
        end
        st_d.pend = (st_q.pend && !clr) || set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;

    // R9
    irq_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(strobe));

    // R6
    irq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(thr_ok));

    // R7
    irq_fall_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr));

    // R9
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(last_q));

    generate
        if (RISING) begin : g_rise_chk
            // R3
            rise_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq) |-> ($past(last_q) < $past(thr)) && ($past(count) >= $past(thr)));
        end else begin : g_fall_chk
            // R4
            fall_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq) |-> ($past(last_q) > $past(thr)) && ($past(count) <= $past(thr)));
        end
    endgenerate

endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
    import fli_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               tx_push,
    input  logic               tx_pop,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    output logic               rx_irq,
    output logic               tx_irq
);

    localparam int N_DIR = 2;

    logic [N_DIR-1:0][CNT_W-1:0] cnt_a;
    logic [N_DIR-1:0][CNT_W-1:0] thr_a;
    logic [N_DIR-1:0][SEL_W-1:0] sel_a;
    logic [N_DIR-1:0]            strb_a;
    logic [N_DIR-1:0]            clr_a;
    logic [N_DIR-1:0]            ok_a;
    logic [N_DIR-1:0]            irq_a;
    logic [SEL_W-1:0]            rx_sel, tx_sel;
    logic                        rx_clr, tx_clr;

    fli_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_sel    (rx_sel),
        .tx_sel    (tx_sel),
        .rx_clr    (rx_clr),
        .tx_clr    (tx_clr)
    );

    // Index 0 is the receive direction, index 1 the transmit direction
    assign cnt_a  = {tx_count, rx_count};
    assign sel_a  = {tx_sel, rx_sel};
    assign strb_a = {tx_push | tx_pop, rx_push | rx_pop};
    assign clr_a  = {tx_clr, rx_clr};

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        localparam bit RISE = (g == 0);

        fli_thresh #(
            .DEPTH  (DEPTH),
            .CNT_W  (CNT_W),
            .RISING (RISE)
        ) u_thr (
            .sel    (sel_a[g]),
            .thr    (thr_a[g]),
            .thr_ok (ok_a[g])
        );

        fli_cross #(
            .CNT_W  (CNT_W),
            .RISING (RISE)
        ) u_cross (
            .clk    (clk),
            .rst_n  (rst_n),
            .count  (cnt_a[g]),
            .strobe (strb_a[g]),
            .thr    (thr_a[g]),
            .thr_ok (ok_a[g]),
            .clr    (clr_a[g]),
            .irq    (irq_a[g])
        );
    end

    assign rx_irq = irq_a[0];
    assign tx_irq = irq_a[1];

    // R8
    sel_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !(rx_push | rx_pop)) |=> !$rose(rx_irq));

endmodule

// File: tb/tb_fifo_lvl_irq.sv
module tb_fifo_lvl_irq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rx_count = '0, tx_count = '0;
    logic        rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_irq, tx_irq;

    int checks = 0;
    int failures = 0;

    // reference model state
    int  m_rx_sel = 2, m_tx_sel = 2;
    int  m_rx_last = 0, m_tx_last = 0;
    bit  m_rx_p = 0, m_tx_p = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_lvl_irq dut (
        .clk(clk), .rst_n(rst_n),
        .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_count(tx_count), .tx_push(tx_push), .tx_pop(tx_pop),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    function automatic int thr_of(int code, bit rx);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 14;
            5: return rx ? 16 : 0;
            default: return -1;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one edge, advance the model, compare.
    task automatic tick(string tag);
        int  rt, tt;
        bit  rs, ts, rset, tset, rclr, tclr;
        rt = thr_of(m_rx_sel, 1);
        tt = thr_of(m_tx_sel, 0);
        rs = rx_push | rx_pop;
        ts = tx_push | tx_pop;
        rset = rs && rt >= 0 && m_rx_last < rt && int'(rx_count) >= rt;
        tset = ts && tt >= 0 && m_tx_last > tt && int'(tx_count) <= tt;
        rclr = reg_wr && reg_addr == 2'd1 && reg_wdata[0];
        tclr = reg_wr && reg_addr == 2'd1 && reg_wdata[1];
        if (rs) m_rx_last = int'(rx_count);
        if (ts) m_tx_last = int'(tx_count);
        m_rx_p = (m_rx_p && !rclr) || rset;
        m_tx_p = (m_tx_p && !tclr) || tset;
        if (reg_wr && reg_addr == 2'd0) begin
            m_rx_sel = int'(reg_wdata[5:3]);
            m_tx_sel = int'(reg_wdata[2:0]);
        end
        @(posedge clk);
        @(negedge clk);
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; reg_wr = 0;
        check({tag, " rx_irq"}, {31'd0, rx_irq}, {31'd0, m_rx_p});
        check({tag, " tx_irq"}, {31'd0, tx_irq}, {31'd0, m_tx_p});
    endtask

    task automatic rx_step(int c, string tag);
        rx_push = (c >= int'(rx_count));
        rx_pop  = (c <  int'(rx_count));
        rx_count = 5'(c);
        tick(tag);
    endtask

    task automatic tx_step(int c, string tag);
        tx_push = (c >= int'(tx_count));
        tx_pop  = (c <  int'(tx_count));
        tx_count = 5'(c);
        tick(tag);
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d, string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(tag);
    endtask

    task automatic reg_read(logic [1:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        check("R2 rx_irq reset", {31'd0, rx_irq}, 32'd0);
        check("R2 tx_irq reset", {31'd0, tx_irq}, 32'd0);
        reg_read(2'd0, 32'h12, "R2 select reset value");

        // R1 layout and masking
        reg_write(2'd0, 32'hFFFF_FFE5, "R1 write");
        reg_read(2'd0, 32'h25, "R1 readback");
        reg_read(2'd1, 32'h0, "R1 clear reg reads zero");
        reg_read(2'd2, 32'h0, "R1 unmapped reads zero");
        reg_write(2'd0, 32'h12, "R1 restore");

        // R3 default receive threshold 8, R5 staying above
        for (int c = 1; c <= 10; c++) rx_step(c, "R3 rx ramp thr8");
        reg_write(2'd1, 32'h1, "R7 clear rx");
        for (int c = 11; c <= 16; c++) rx_step(c, "R5 rx stays above");
        rx_step(16, "R5 rx full repeat");
        // R5 jump across threshold
        rx_step(6, "R5 rx drop");
        rx_step(10, "R5 rx jump across");
        reg_write(2'd1, 32'h1, "R7 clear rx");

        // R4 transmit default threshold
        for (int c = 1; c <= 16; c++) tx_step(c, "R4 tx fill no irq");
        for (int c = 15; c >= 5; c--) tx_step(c, "R4 tx drain thr8");
        tx_step(3, "R5 tx stays below");

        // R7 clear and crossing on the same edge
        rx_step(4, "R7 rx below");
        rx_push = 1; rx_count = 5'd9;
        reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h3;
        tick("R7 clear with crossing");
        reg_write(2'd1, 32'h3, "R7 clear both");

        // R8 select write while already past new threshold
        rx_step(10, "R8 rx at 10");
        reg_write(2'd0, {26'd0, 3'd0, 3'd2}, "R8 lower rx threshold");
        rx_step(11, "R8 rx step stays above");
        reg_read(2'd0, 32'h02, "R8 readback");

        // R9 count change without strobe
        rx_step(0, "R9 rx empty");
        reg_write(2'd0, 32'h12, "R9 thr8");
        rx_count = 5'd10;
        tick("R9 no strobe ignored");
        rx_count = 5'd10; rx_push = 1;
        tick("R9 strobe sees crossing");
        reg_write(2'd1, 32'h3, "R9 clear");

        // R3 R4 R6 sweep of every select code in both directions
        rx_step(0, "R3 sweep prep");
        tx_step(0, "R4 sweep prep");
        for (int code = 0; code < 8; code++) begin
            reg_write(2'd0, 32'((code << 3) | code), "R6 sweep select");
            reg_write(2'd1, 32'h3, "R7 sweep clear");
            for (int c = 1; c <= 16; c++) begin
                rx_step(c, "R3 sweep rx up");
                tx_step(c, "R4 sweep tx up");
            end
            reg_write(2'd1, 32'h3, "R7 sweep clear top");
            for (int c = 15; c >= 0; c--) begin
                rx_step(c, "R3 sweep rx down");
                tx_step(c, "R4 sweep tx down");
            end
            for (int c = 1; c <= 16; c++) rx_step(c, "R6 sweep rx second ramp");
            rx_step(0, "R3 sweep rx reset level");
            reg_write(2'd1, 32'h3, "R7 sweep clear end");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule